// File: doc/BRIEF.md
# Extended Segment Override Sequencer

This block sits beside the decode stage of a 16-bit microcontroller core. An extended-sequence instruction opens a short window that covers the instructions after it. The window lasts from one to four instructions. While it is open, three things change:

- The upper address byte of every long or indirect data access comes from a segment operand instead of the page logic.
- Register-mode and bit-mode accesses are steered into the extended register space.
- Standard interrupts, peripheral event transfers and class A traps are held off.

The window closes after its last instruction retires, or at once when a class B trap condition is seen. When it closes, the page-derived upper bits, the standard register space and the interrupt path all come back.

Decode raises the start strobe for one cycle, in the cycle the extended instruction completes. With the strobe it supplies the two-bit length code and the operand for the instruction form in use. The register form takes its segment from the low byte of a word register. The immediate form takes it from the constant byte of the four-byte encoding. The strobe may arrive while a window is already open. It then reloads the window rather than nesting a second one inside it.

Top module: `seg_override_seq`

## Requirements
- R1: After reset the window is closed: `addr_hi_o` equals `page_hi_i`, and `ext_sfr_o` and `irq_lock_o` are 0.
- R2: A window opened by a start strobe stays open, with a constant `addr_hi_o`, until its count of retire pulses is used up or a trap closes it. The window closes in the cycle after the retire pulse that ends it.
- R3: Length code c (0..3 on `len_code_i`) gives a window of exactly c+1 counted retire pulses, so code 0 gives 1 and code 3 gives 4.
- R4: While the window is open, `addr_hi_o` equals the latched segment and ignores `page_hi_i`.
- R5: With `form_imm_i`=0 the segment is taken from `seg_reg_i` (the low byte of the word register). With `form_imm_i`=1 it is taken from `seg_imm_i`.
- R6: `ext_sfr_o` and `irq_lock_o` are both 1 exactly while the window is open.
- R7: The override is in force in the first cycle after the start strobe, with no idle cycle in between.
- R8: A retire pulse in the same cycle as the start strobe belongs to the starting instruction and is not counted.
- R9: `trap_b_i` high while the window is open closes the window in the next cycle.
- R10: `trap_b_i` high in the same cycle as a start strobe wins, so no window opens.
- R11: A start strobe during an open window reloads both the count and the segment, and does not nest.
- R12: Retire pulses and trap indications while the window is closed leave it closed and `addr_hi_o` following `page_hi_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe from decode for an extended-sequence instruction |
| form_imm_i | input | 1 | 1 = immediate form, 0 = register form |
| seg_reg_i | input | 8 | Low byte of the segment word register (register form) |
| seg_imm_i | input | 8 | Segment constant byte (immediate form) |
| len_code_i | input | 2 | Window length minus one |
| retire_i | input | 1 | One pulse per completed instruction |
| trap_b_i | input | 1 | Class B trap condition |
| page_hi_i | input | 8 | Page-derived address bits A23..A16 |
| addr_hi_o | output | 8 | Effective address bits A23..A16 |
| ext_sfr_o | output | 1 | 1 = extended register space selected |
| irq_lock_o | output | 1 | 1 = interrupts, event transfers and class A traps masked |

## Verification
The hardest states to reach are those where events land on the same edge. Examples are a start strobe together with its own retire pulse, with a trap, or inside an open window that has exactly one count left. Uncoordinated random stimulus hits these only rarely. The bench therefore drives each of them by name, one cycle at a time. It then runs several thousand seeded random cycles with frequent retires and a steady trickle of starts and traps, so reloads on the last count and traps on the opening edge also come up. Each cycle is compared with a bench-side model built from the requirements.

// File: rtl/seg_ovr_pkg.sv
package seg_ovr_pkg;
  typedef enum logic {
    FORM_REG = 1'b0,
    FORM_IMM = 1'b1
  } seg_form_e;
endpackage

// File: rtl/seg_ovr_rst_sync.sv
module seg_ovr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/seg_ovr_operand.sv
module seg_ovr_operand
  import seg_ovr_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  seg_form_e          form_i,
  input  logic [SEG_W-1:0]   reg_seg_i,
  input  logic [SEG_W-1:0]   imm_seg_i,
  output logic [SEG_W-1:0]   seg_o
);
  always_comb begin
    unique case (form_i)
      FORM_IMM: seg_o = imm_seg_i;
      default:  seg_o = reg_seg_i;
    endcase
  end
endmodule

// File: rtl/seg_ovr_window.sv
module seg_ovr_window #(
  parameter int SEG_W = 8,
  parameter int LEN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic             retire_i,
  input  logic             trap_i,
  output logic             active_o,
  output logic [SEG_W-1:0] seg_o
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEG_W-1:0] seg_q, seg_d;
  logic             cnt_en, seg_en;
  logic             open_w;

  assign open_w = (cnt_q != '0);

  // next-state: trap beats start, start beats retire
  always_comb begin
    cnt_d  = cnt_q;
    seg_d  = seg_q;
    cnt_en = 1'b0;
    seg_en = 1'b0;
    if (trap_i) begin
      cnt_d  = '0;
      cnt_en = open_w;
    end else if (start_i) begin
      cnt_d  = {1'b0, len_code_i} + CNT_W'(1);
      cnt_en = 1'b1;
      seg_d  = seg_i;
      seg_en = 1'b1;
    end else if (retire_i && open_w) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seg_q <= '0;
    else if (seg_en) seg_q <= seg_d;
  end

  assign active_o = open_w;
  assign seg_o    = seg_q;
endmodule

// File: rtl/seg_ovr_steer.sv
module seg_ovr_steer #(
  parameter int SEG_W = 8
) (
  input  logic             active_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [SEG_W-1:0] page_hi_i,
  output logic [SEG_W-1:0] addr_hi_o,
  output logic             ext_sfr_o,
  output logic             irq_lock_o
);
  always_comb begin
    addr_hi_o  = active_i ? seg_i : page_hi_i;
    ext_sfr_o  = active_i;
    irq_lock_o = active_i;
  end
endmodule

// File: rtl/seg_override_seq.sv
module seg_override_seq
  import seg_ovr_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int LEN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             form_imm_i,
  input  logic [SEG_W-1:0] seg_reg_i,
  input  logic [SEG_W-1:0] seg_imm_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             retire_i,
  input  logic             trap_b_i,
  input  logic [SEG_W-1:0] page_hi_i,
  output logic [SEG_W-1:0] addr_hi_o,
  output logic             ext_sfr_o,
  output logic             irq_lock_o
);
  logic             rst_core_n;
  logic [SEG_W-1:0] sel_seg;
  logic [SEG_W-1:0] win_seg;
  logic             win_active;
  seg_form_e        form;

  assign form = form_imm_i ? FORM_IMM : FORM_REG;

  seg_ovr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_core_n)
  );

  seg_ovr_operand #(.SEG_W(SEG_W)) u_opnd (
    .form_i   (form),
    .reg_seg_i(seg_reg_i),
    .imm_seg_i(seg_imm_i),
    .seg_o    (sel_seg)
  );

  seg_ovr_window #(.SEG_W(SEG_W), .LEN_W(LEN_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_core_n),
    .start_i   (start_i),
    .len_code_i(len_code_i),
    .seg_i     (sel_seg),
    .retire_i  (retire_i),
    .trap_i    (trap_b_i),
    .active_o  (win_active),
    .seg_o     (win_seg)
  );

  seg_ovr_steer #(.SEG_W(SEG_W)) u_steer (
    .active_i  (win_active),
    .seg_i     (win_seg),
    .page_hi_i (page_hi_i),
    .addr_hi_o (addr_hi_o),
    .ext_sfr_o (ext_sfr_o),
    .irq_lock_o(irq_lock_o)
  );
endmodule

// File: rtl/seg_ovr_chk.sv
module seg_ovr_chk #(
  parameter int SEG_W = 8,
  parameter int LEN_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             form_imm_i,
  input logic [SEG_W-1:0] seg_reg_i,
  input logic [SEG_W-1:0] seg_imm_i,
  input logic [LEN_W-1:0] len_code_i,
  input logic             retire_i,
  input logic             trap_b_i,
  input logic [SEG_W-1:0] page_hi_i,
  input logic [SEG_W-1:0] addr_hi_o,
  input logic             ext_sfr_o,
  input logic             irq_lock_o
);
  localparam int MAX_LEN = 1 << LEN_W;
  localparam int RC_W    = LEN_W + 2;

  logic [RC_W-1:0] ret_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ret_seen_q <= '0;
    else if (start_i)                  ret_seen_q <= '0;
    else if (ext_sfr_o && retire_i && ret_seen_q != '1)
                                       ret_seen_q <= ret_seen_q + RC_W'(1);
  end

  assert_lock_tracks_ext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sfr_o == irq_lock_o);

  assert_closed_page_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sfr_o |-> addr_hi_o == page_hi_i);

  assert_opens_next_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !trap_b_i |=> ext_sfr_o);

  assert_seg_pick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !trap_b_i |=> addr_hi_o == $past(form_imm_i ? seg_imm_i : seg_reg_i));

  assert_trap_close_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_b_i |=> !ext_sfr_o);

  assert_idle_stays_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sfr_o && !start_i |=> !ext_sfr_o);

  assert_hold_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sfr_o && !retire_i && !trap_b_i && !start_i |=> ext_sfr_o && $stable(addr_hi_o));

  assert_len_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sfr_o |-> ret_seen_q < RC_W'(MAX_LEN));

  assert_len_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !trap_b_i && len_code_i == '0) ##1 (retire_i && !start_i && !trap_b_i)
      |=> !ext_sfr_o);
endmodule

bind seg_override_seq seg_ovr_chk #(.SEG_W(SEG_W), .LEN_W(LEN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_core_n),
  .start_i   (start_i),
  .form_imm_i(form_imm_i),
  .seg_reg_i (seg_reg_i),
  .seg_imm_i (seg_imm_i),
  .len_code_i(len_code_i),
  .retire_i  (retire_i),
  .trap_b_i  (trap_b_i),
  .page_hi_i (page_hi_i),
  .addr_hi_o (addr_hi_o),
  .ext_sfr_o (ext_sfr_o),
  .irq_lock_o(irq_lock_o)
);

// File: tb/test_seg_override_seq.sv
module test_seg_override_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, form_imm = 1'b0, retire = 1'b0, trap = 1'b0;
  logic [7:0] seg_reg = '0, seg_imm = '0, page = '0;
  logic [1:0] len_code = '0;
  logic [7:0] addr_hi;
  logic       ext_sfr, irq_lock;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0;
  logic [7:0] m_seg = '0;

  always #2.5 clk = ~clk;

  seg_override_seq i_seg_override_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .form_imm_i(form_imm),
    .seg_reg_i(seg_reg), .seg_imm_i(seg_imm), .len_code_i(len_code),
    .retire_i(retire), .trap_b_i(trap), .page_hi_i(page),
    .addr_hi_o(addr_hi), .ext_sfr_o(ext_sfr), .irq_lock_o(irq_lock)
  );

  // requirement model: trap > start > retire (R8 R9 R10 R11)
  always @(posedge clk) begin
    if (!rst_n) m_cnt = 0;
    else if (trap) m_cnt = 0;
    else if (start) begin
      m_cnt = int'(len_code) + 1;
      m_seg = form_imm ? seg_imm : seg_reg;
    end else if (retire && m_cnt != 0) m_cnt = m_cnt - 1;
  end

  function automatic logic [7:0] exp_addr(int cnt, logic [7:0] s, logic [7:0] p);
    return (cnt != 0) ? s : p;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic st, logic fi, logic [7:0] sr, logic [7:0] si,
                     logic [1:0] lc, logic rt, logic tp, logic [7:0] pg);
    @(negedge clk);
    start = st; form_imm = fi; seg_reg = sr; seg_imm = si;
    len_code = lc; retire = rt; trap = tp; page = pg;
    #1;
    chk((m_cnt != 0) ? "R4" : "R1", addr_hi, exp_addr(m_cnt, m_seg, pg));
    chk("R6", {ext_sfr, irq_lock}, (m_cnt != 0) ? 2'b11 : 2'b00);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 8'h00, 2'd0, 0, 0, 8'(i * 37 + 5));
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    repeat (4) @(posedge clk);
    #1;
    chk("R1", {addr_hi, ext_sfr, irq_lock}, {8'h00, 2'b00});
    @(negedge clk); rst_n = 1'b1;
    idle(4);

    // R3: each length code, register form, R7 next-cycle activation
    for (int c = 0; c < 4; c++) begin
      cyc(1, 0, 8'h40 + 8'(c), 8'hEE, 2'(c), 0, 0, 8'h11);
      for (int k = 0; k <= c; k++) begin
        cyc(0, 0, 0, 0, 0, 1, 0, 8'h22);
        chk("R7", ext_sfr, 1'b1);
        chk("R3", addr_hi, 8'h40 + 8'(c));
      end
      cyc(0, 0, 0, 0, 0, 0, 0, 8'h33);
      chk("R3", {addr_hi, ext_sfr}, {8'h33, 1'b0});
    end

    // R5 immediate form, R2 hold without retire
    cyc(1, 1, 8'h12, 8'hA5, 2'd1, 0, 0, 8'h00);
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0, 0, 0, 8'(k));
    chk("R5", {addr_hi, ext_sfr}, {8'hA5, 1'b1});
    chk("R2", irq_lock, 1'b1);
    cyc(0, 0, 0, 0, 0, 1, 0, 8'h01);
    cyc(0, 0, 0, 0, 0, 1, 0, 8'h02);
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h03);
    chk("R2", {addr_hi, ext_sfr}, {8'h03, 1'b0});

    // R8: own retire not counted, length one
    cyc(1, 0, 8'h5C, 8'h00, 2'd0, 1, 0, 8'h00);
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h07);
    chk("R8", {addr_hi, ext_sfr}, {8'h5C, 1'b1});
    cyc(0, 0, 0, 0, 0, 1, 0, 8'h07);
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h07);
    chk("R8", ext_sfr, 1'b0);

    // R9 trap mid-window
    cyc(1, 1, 8'h00, 8'h77, 2'd3, 0, 0, 8'h00);
    cyc(0, 0, 0, 0, 0, 1, 1, 8'h09);
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h09);
    chk("R9", {addr_hi, ext_sfr, irq_lock}, {8'h09, 2'b00});

    // R10 trap with start
    cyc(1, 1, 8'h00, 8'h66, 2'd3, 0, 1, 8'h0A);
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h0B);
    chk("R10", {addr_hi, ext_sfr}, {8'h0B, 1'b0});

    // R11 reload on the last count
    cyc(1, 0, 8'h31, 8'h00, 2'd0, 0, 0, 8'h00);
    cyc(1, 1, 8'h00, 8'h32, 2'd2, 1, 0, 8'h00);
    cyc(0, 0, 0, 0, 0, 1, 0, 8'h0C);
    cyc(0, 0, 0, 0, 0, 1, 0, 8'h0C);
    chk("R11", {addr_hi, ext_sfr}, {8'h32, 1'b1});
    cyc(0, 0, 0, 0, 0, 1, 0, 8'h0C);
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h0C);
    chk("R11", ext_sfr, 1'b0);

    // R12 idle retire/trap
    cyc(0, 0, 0, 0, 0, 1, 1, 8'hD0);
    cyc(0, 0, 0, 0, 0, 1, 0, 8'hD1);
    cyc(0, 0, 0, 0, 0, 0, 0, 8'hD2);
    chk("R12", {addr_hi, ext_sfr}, {8'hD2, 1'b0});

    // random mix, compared each cycle to the model (R2 R4 R6 R11)
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 8) == 0, 1'($urandom), 8'($urandom), 8'($urandom),
          2'($urandom), ($urandom % 2) == 0, ($urandom % 20) == 0, 8'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule